// File: doc/BRIEF.md
# Current-Mode PWM Pulse Generator with Duty Ceiling

This block is the clocked core of a peak-current-mode switching stage. It counts oscillator ticks into switching periods of either two or four sub-periods, picked by a mode strap. At the start of every period it raises the gate-drive request, provided neither comparator is already high. The request then falls for the rest of the period when the PWM comparator reports that the sensed current has crossed the error level. It also falls when the current-limit comparator trips.

A hard off-window at the end of every period caps the duty cycle. In the two-tick mode the gate is held off for the second sub-period, a 50% ceiling. In the four-tick mode it is held off for the fourth sub-period, a 75% ceiling. Each period start also emits a one-clock strobe that a soft-start counter can use. The strap is sampled only at period boundaries. When the run enable is low, all activity stops and the gate request stays low.

Top module: `pwm_pulse_core`

## Requirements
- R1: While `rstN` is low, or on the clock after `runEn` was sampled low, `gateReq` and `cycleStrobe` are both 0.
- R2: With `quadMode`=0 a period spans 2 oscillator ticks and `gateReq` is forced low from the clock after the second tick of the period until the next period start (at most 50% on-time).
- R3: With `quadMode`=1 a period spans 4 oscillator ticks and `gateReq` is forced low from the clock after the fourth tick until the next period start (at most 75% on-time).
- R4: `gateReq` rises only on the clock after a period-start tick, and does so when both `pwmTrip` and `ilimTrip` are low at that tick.
- R5: `pwmTrip` sampled high drives `gateReq` low on the next clock, and it stays low until the next period start even after `pwmTrip` falls.
- R6: `ilimTrip` sampled high ends the on-time in the same way as R5, cycle by cycle.
- R7: If either comparator is high at the period-start tick, that period produces no gate pulse.
- R8: `cycleStrobe` is high for exactly one clock, the clock after each period-start tick.
- R9: `quadMode` is sampled only at period-start ticks (and while `runEn` is low); a change in mid-period leaves that period's length unchanged.
- R10: The first `oscTick` sampled with `runEn` high begins a period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| oscTick | input | 1 | One-clock pulse per oscillator sub-period |
| pwmTrip | input | 1 | PWM comparator: sensed current above error level |
| ilimTrip | input | 1 | Current-limit comparator tripped |
| runEn | input | 1 | High when out of lockout |
| quadMode | input | 1 | 0: two-tick period (50%), 1: four-tick period (75%) |
| gateReq | output | 1 | Gate-drive request |
| cycleStrobe | output | 1 | One-clock pulse at each period start |

## Verification
Both outputs are registered. Each result is therefore due exactly one clock after the input sample that causes it: a period-start tick, a comparator trip, the tick that opens the off-window, or `runEn` going low. The bench drives inputs just after a falling edge and then updates its expected state for the coming rising edge. It compares both outputs at the following falling edge, so every comparison falls one register stage after its stimulus. Duty-ceiling checks count high gate cycles over whole periods of known length.

// File: rtl/pwm_core_pkg.sv
package pwm_core_pkg;
  // strobes from control to the sub-period datapath
  typedef struct packed {
    logic clr;      // lockout: zero count, follow strap
    logic restart;  // period start: zero count, latch strap
    logic adv;      // advance to next sub-period
  } seqStrobe_t;
endpackage

// File: rtl/pwm_sub_count.sv
module pwm_sub_count import pwm_core_pkg::*; #(
  parameter int SUB_LO = 2,
  parameter int SUB_HI = 4,
  localparam int CNT_W = $clog2(SUB_HI)
) (
  input  logic       clk,
  input  logic       rstN,
  input  seqStrobe_t seq,
  input  logic       quadStrap,
  output logic       atLast,
  output logic       nextLast
);
  localparam logic [CNT_W-1:0] LAST_LO = CNT_W'(SUB_LO - 1);
  localparam logic [CNT_W-1:0] LAST_HI = CNT_W'(SUB_HI - 1);

  logic [CNT_W-1:0] subCnt;
  logic             quadActive;
  logic [CNT_W-1:0] lastIdx;
  logic [CNT_W-1:0] subInc;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      subCnt     <= '0;
      quadActive <= 1'b0;
    end else if (seq.clr || seq.restart) begin
      subCnt     <= '0;
      quadActive <= quadStrap;
    end else if (seq.adv) begin
      subCnt     <= subInc;
    end
  end

  assign lastIdx  = quadActive ? LAST_HI : LAST_LO;
  assign subInc   = subCnt + 1'b1;
  assign atLast   = (subCnt == lastIdx);
  assign nextLast = (subInc == lastIdx);
endmodule

// File: rtl/pwm_gate_ctrl.sv
module pwm_gate_ctrl import pwm_core_pkg::*; (
  input  logic       clk,
  input  logic       rstN,
  input  logic       runEn,
  input  logic       oscTick,
  input  logic       pwmTrip,
  input  logic       ilimTrip,
  input  logic       atLast,
  input  logic       nextLast,
  output seqStrobe_t seq,
  output logic       gateReq,
  output logic       cycleStrobe
);
  logic started;
  logic periodStart;
  logic anyTrip;

  assign anyTrip     = pwmTrip | ilimTrip;
  assign periodStart = runEn & oscTick & (~started | atLast);

  always_comb begin
    seq.clr     = ~runEn;
    seq.restart = periodStart;
    seq.adv     = runEn & oscTick & ~periodStart;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      started     <= 1'b0;
      gateReq     <= 1'b0;
      cycleStrobe <= 1'b0;
    end else begin
      cycleStrobe <= periodStart;
      if (!runEn) begin
        started <= 1'b0;
        gateReq <= 1'b0;
      end else if (periodStart) begin
        started <= 1'b1;
        gateReq <= ~anyTrip;
      end else if ((seq.adv && nextLast) || anyTrip) begin
        gateReq <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/pwm_pulse_core.sv
module pwm_pulse_core import pwm_core_pkg::*; #(
  parameter int SUB_LO = 2,
  parameter int SUB_HI = 4
) (
  input  logic clk,
  input  logic rstN,
  input  logic oscTick,
  input  logic pwmTrip,
  input  logic ilimTrip,
  input  logic runEn,
  input  logic quadMode,
  output logic gateReq,
  output logic cycleStrobe
);
  seqStrobe_t seq;
  logic atLast;
  logic nextLast;

  pwm_gate_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .runEn(runEn), .oscTick(oscTick),
    .pwmTrip(pwmTrip), .ilimTrip(ilimTrip), .atLast(atLast),
    .nextLast(nextLast), .seq(seq), .gateReq(gateReq),
    .cycleStrobe(cycleStrobe)
  );

  pwm_sub_count #(.SUB_LO(SUB_LO), .SUB_HI(SUB_HI)) u_cnt (
    .clk(clk), .rstN(rstN), .seq(seq), .quadStrap(quadMode),
    .atLast(atLast), .nextLast(nextLast)
  );
endmodule

// File: rtl/pwm_pulse_core_chk.sv
module pwm_pulse_core_chk (
  input logic clk,
  input logic rstN,
  input logic oscTick,
  input logic pwmTrip,
  input logic ilimTrip,
  input logic runEn,
  input logic gateReq,
  input logic cycleStrobe
);
  p_lockout_r1: assert property (@(posedge clk) disable iff (!rstN)
    !runEn |=> (!gateReq && !cycleStrobe));

  p_rise_at_start_r4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(gateReq) |-> cycleStrobe);

  p_pwm_cut_r5: assert property (@(posedge clk) disable iff (!rstN)
    pwmTrip |=> !gateReq);

  p_ilim_cut_r6: assert property (@(posedge clk) disable iff (!rstN)
    ilimTrip |=> !gateReq);

  p_single_strobe_r8: assert property (@(posedge clk) disable iff (!rstN)
    cycleStrobe |=> !cycleStrobe);

  p_strobe_needs_tick_r10: assert property (@(posedge clk) disable iff (!rstN)
    (!oscTick || !runEn) |=> !cycleStrobe);

  p_hold_on_r2: assert property (@(posedge clk) disable iff (!rstN)
    (gateReq && !oscTick && runEn && !pwmTrip && !ilimTrip) |=> gateReq);
endmodule

bind pwm_pulse_core pwm_pulse_core_chk u_chk (
  .clk(clk), .rstN(rstN), .oscTick(oscTick), .pwmTrip(pwmTrip),
  .ilimTrip(ilimTrip), .runEn(runEn), .gateReq(gateReq),
  .cycleStrobe(cycleStrobe)
);

// File: tb/pwm_pulse_core_test.sv
`timescale 1ns/1ps
module pwm_pulse_core_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic oscTick = 1'b0, pwmTrip = 1'b0, ilimTrip = 1'b0;
  logic runEn = 1'b0, quadMode = 1'b0;
  logic gateReq, cycleStrobe;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // expected-state model built from the requirements
  bit mStarted = 0, mQuad = 0, mGate = 0, mStrobe = 0;
  int mPos = 0;

  always #2.5 clk = ~clk;

  pwm_pulse_core uut (
    .clk(clk), .rstN(rstN), .oscTick(oscTick), .pwmTrip(pwmTrip),
    .ilimTrip(ilimTrip), .runEn(runEn), .quadMode(quadMode),
    .gateReq(gateReq), .cycleStrobe(cycleStrobe)
  );

  task automatic check(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int periodLen(bit q);
    return q ? 4 : 2;
  endfunction

  task automatic modelStep(bit t, bit p, bit i, bit r, bit q);
    mStrobe = 0;
    if (!r) begin
      mStarted = 0; mPos = 0; mGate = 0; mQuad = q;
    end else if (t && (!mStarted || mPos == periodLen(mQuad) - 1)) begin
      mStarted = 1; mPos = 0; mQuad = q; mStrobe = 1;
      mGate = !(p || i);
    end else begin
      if (t) begin
        mPos++;
        if (mPos == periodLen(mQuad) - 1) mGate = 0;
      end
      if (p || i) mGate = 0;
    end
  endtask

  // drive at a falling edge, compare at the next falling edge
  task automatic cyc(bit t, bit p, bit i, bit r, bit q, string tag);
    oscTick = t; pwmTrip = p; ilimTrip = i; runEn = r; quadMode = q;
    modelStep(t, p, i, r, q);
    @(negedge clk);
    check({tag, " gateReq"}, gateReq, mGate);
    check({tag, " cycleStrobe R8"}, cycleStrobe, mStrobe);
  endtask

  // run whole periods with tick spacing T, no trips, count gate-high clocks
  task automatic dutyRun(bit q, int T, string tag);
    int highs = 0;
    int win = periodLen(q) * T;
    int cnt = -1;
    for (int k = 0; k < win * 4; k++) begin
      cyc((k % T) == 0, 0, 0, 1, q, tag);
      if (cnt < 0 && cycleStrobe && k > win) cnt = 0;
      if (cnt >= 0 && cnt < win) begin
        if (gateReq) highs++;
        cnt++;
      end
    end
    check({tag, " duty ceiling"}, (highs == (periodLen(q) - 1) * T), 1'b1);
  endtask

  initial begin
    #1000000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    process::self().srandom(32'd4711);
    @(negedge clk);
    // R1: reset state
    check("R1 reset gateReq", gateReq, 1'b0);
    check("R1 reset cycleStrobe", cycleStrobe, 1'b0);
    for (int k = 0; k < 3; k++) cyc(1, 0, 0, 0, 0, "R1 reset");
    rstN = 1'b1;
    for (int k = 0; k < 4; k++) cyc(1, 0, 0, 0, 1, "R1 lockout");

    // R10: first tick under run starts a period, R4 gate rises
    cyc(0, 0, 0, 1, 0, "R10 idle");
    cyc(1, 0, 0, 1, 0, "R10 first tick");
    check("R4 gate after start", gateReq, 1'b1);
    check("R8 strobe after start", cycleStrobe, 1'b1);

    // R2 / R3 duty ceilings
    dutyRun(0, 3, "R2");
    dutyRun(1, 3, "R3");
    dutyRun(1, 1, "R3 fast");
    dutyRun(0, 1, "R2 fast");

    // R5: pwm trip mid on-time, then release: stays low until next start
    cyc(0, 0, 0, 0, 1, "R1 drop");
    check("R1 drop gate", gateReq, 1'b0);
    cyc(1, 0, 0, 1, 1, "R5 start");
    cyc(0, 1, 0, 1, 1, "R5 trip");
    check("R5 gate cut", gateReq, 1'b0);
    cyc(0, 0, 0, 1, 1, "R5 released");
    cyc(1, 0, 0, 1, 1, "R5 tick");
    check("R5 stays off", gateReq, 1'b0);
    cyc(1, 0, 0, 1, 1, "R5 tick");
    cyc(1, 0, 0, 1, 1, "R5 tick");
    cyc(1, 0, 0, 1, 1, "R5 next start");
    check("R5 back on", gateReq, 1'b1);

    // R6: current-limit trip
    cyc(0, 0, 1, 1, 1, "R6 trip");
    check("R6 gate cut", gateReq, 1'b0);
    cyc(0, 0, 0, 1, 1, "R6 released");
    check("R6 stays off", gateReq, 1'b0);

    // R7: comparator high at period start, then R9 strap change mid-period
    for (int k = 0; k < 3; k++) cyc(1, 0, 0, 1, 1, "R7 walk");
    cyc(1, 0, 1, 1, 1, "R7 start tripped");
    check("R7 suppressed", gateReq, 1'b0);
    check("R7 strobe still", cycleStrobe, 1'b1);
    cyc(1, 0, 0, 1, 0, "R9 strap flip");
    cyc(1, 0, 0, 1, 0, "R9 tick3");
    cyc(1, 0, 0, 1, 0, "R9 tick4");
    check("R9 no early start", cycleStrobe, 1'b0);
    cyc(1, 0, 0, 1, 0, "R9 boundary");
    check("R9 start at boundary", cycleStrobe, 1'b1);
    cyc(1, 0, 0, 1, 0, "R9 half");
    check("R9 new mode off", gateReq, 1'b0);

    // constrained random mix
    for (int k = 0; k < 20000; k++) begin
      bit t = ($urandom % 3) == 0;
      bit p = ($urandom % 17) == 0;
      bit i = ($urandom % 29) == 0;
      bit r = ($urandom % 200) != 0;
      bit q = ($urandom % 300) == 0 ? ~quadMode : quadMode;
      cyc(t, p, i, r, q, "R5 R6 R7 random");
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule